// File: doc/BRIEF.md
# CAN Receive Mailbox Bank with Coherency Lock

This block sits between a CAN frame decoder and a CPU register port. It holds a bank of receive mailboxes. Each mailbox has a control word, an identifier word and eight data bytes. The control word carries a state code, a length and a capture time. The decoder offers each decoded frame on a valid/ready stream, and that includes frames the same controller transmitted and then heard back from the bus. The block compares the frame identifier against every active mailbox through a global compare mask. It writes the frame into the lowest-numbered mailbox that matches, raises that mailbox's flag, and drives the interrupt line when the flag is enabled.

A CPU read of a mailbox control word locks that mailbox, so the identifier and data words read afterwards belong to the same frame. Only one mailbox is locked at any time. The lock moves when another control word is read, and it is released by a read of the free-running timer. A frame that targets the locked mailbox is parked in a single holding register. The stream input then applies back-pressure (`in_ready` low) until the lock moves away and the parked frame is written in. `in_ready` depends only on internal state. A frame offered while `in_ready` is high is consumed on that clock edge: it is stored, parked or dropped. The source must hold `in_valid` and the frame fields stable while `in_ready` is low.

A serviced mailbox keeps its FULL code. Software learns of new frames from the flag register, not by polling codes.

Top module: `can_mb_bank`

## Requirements
- R1: After reset, every mailbox code is 0000 (inactive), the flag register, the enable register, `irq` and `cpu_rdata` are zero, no mailbox is locked, `in_ready` is 1 and the compare mask reads all ones.
- R2: CPU word addresses are as follows. For address `a` below 0x40, the mailbox is `a[5:2]` and the word is `a[1:0]`: 0 is the control word, 1 the identifier, 2 data bytes 0–3 and 3 data bytes 4–7, with byte 0 in bits 7:0. Address 0x40 is the timer, 0x41 the flags (write 1 to clear), 0x42 the flag enables and 0x43 the compare mask. The control word holds the code in bits 27:24, the length in 19:16 and the time stamp in 15:0. Writing a control word takes effect at once: a frame offered in the same cycle is never stored into that mailbox, and code 0100 leaves it active and empty.
- R3: A mailbox is a candidate when its code is not 0000 and `(stored_id ^ frame_id) & mask` is zero. The lowest-numbered candidate receives the frame, and its identifier word is overwritten with the received identifier. A frame with no candidate is consumed and dropped.
- R4: A store writes the length, the data, the identifier and the timer value of the store cycle. The code becomes 0010 (full), or 0110 (overrun) when the prior code was 0010 or 0110.
- R5: A store sets the mailbox's flag bit. A write of 1 clears a flag bit, and a store in the same cycle wins over the clear.
- R6: `irq` is high exactly when some flag bit and its enable bit are both set.
- R7: Reading a control word locks that mailbox and moves the lock away from any other mailbox. Reading the timer releases the lock.
- R8: A frame whose target is locked is parked. `in_ready` stays low from the next cycle until the cycle after the lock leaves that mailbox, and the frame is then stored there.
- R9: A control word read in the same cycle as a store into that mailbox returns the pre-store code with bit 0 (busy) set.
- R10: A full mailbox stays at code 0010 after it has been read and unlocked.
- R11: `cpu_rdata` is loaded in the cycle after `cpu_rd` and holds its value otherwise. The timer advances by one each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded frame offered |
| in_ready | output | 1 | Block can take a frame this cycle |
| in_id | input | ID_W | Frame identifier |
| in_len | input | 4 | Frame data length |
| in_data | input | 64 | Frame data, byte 0 in bits 7:0 |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | IDX_W+3 | CPU word address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, one cycle after the strobe |
| irq | output | 1 | Enabled flag pending |

## Verification
A wrong lock index or a stuck lock shows up as `in_ready` staying low one cycle after a frame to the wrong mailbox, or as a parked frame that never lands. Either fault is visible within two cycles of the read that should have moved the lock. A bad match priority, a bad mask or a bad code update shows at the next read of the flag register or of the control word. A flag or enable fault appears on `irq` in the very next cycle. The bench runs a behavioural model in step with the design and compares `in_ready`, `irq` and `cpu_rdata` on every clock, so any such divergence is reported in the cycle where it first reaches a port.

// File: rtl/can_mb_pkg.sv
package can_mb_pkg;
  localparam logic [3:0] CODE_INACTIVE = 4'b0000;
  localparam logic [3:0] CODE_EMPTY    = 4'b0100;
  localparam logic [3:0] CODE_FULL     = 4'b0010;
  localparam logic [3:0] CODE_OVERRUN  = 4'b0110;
  localparam int         DATA_W        = 64;
  localparam int         LEN_W         = 4;

  // Code a mailbox takes after a store, given its code before it.
  function automatic logic [3:0] code_after_store(input logic [3:0] prev);
    return (prev == CODE_FULL || prev == CODE_OVERRUN) ? CODE_OVERRUN : CODE_FULL;
  endfunction
endpackage

// File: rtl/can_mb_match.sv
module can_mb_match #(
  parameter int NUM   = 16,
  parameter int ID_W  = 11,
  parameter int IDX_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ID_W-1:0]     cand_id,
  input  logic [ID_W-1:0]     mask,
  input  logic [NUM-1:0]      active,
  input  logic [NUM*ID_W-1:0] ids,
  output logic                hit,
  output logic [IDX_W-1:0]    idx
);
  logic [NUM-1:0] hitv;

  for (genvar k = 0; k < NUM; k++) begin : g_cmp
    assign hitv[k] = active[k] && (((ids[k*ID_W +: ID_W] ^ cand_id) & mask) == '0);
  end

  always_comb begin
    idx = '0;
    for (int k = NUM - 1; k >= 0; k--) begin
      if (hitv[k]) idx = IDX_W'(k);
    end
  end
  assign hit = |hitv;

  // R3: the chosen mailbox is always an active one
  assert_hit_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> active[idx]);
endmodule

// File: rtl/can_mb_hold.sv
module can_mb_hold #(
  parameter int FW = 79
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [FW-1:0] in_frame,
  output logic          in_ready,
  input  logic          blocked,
  output logic          cand_valid,
  output logic [FW-1:0] cand_frame
);
  logic          held_q;
  logic [FW-1:0] park_q;

  assign in_ready   = !held_q;
  assign cand_valid = held_q || in_valid;
  assign cand_frame = held_q ? park_q : in_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      park_q <= '0;
    end else if (!held_q && in_valid && blocked) begin
      held_q <= 1'b1;
      park_q <= in_frame;
    end else if (held_q && !blocked) begin
      held_q <= 1'b0;
    end
  end

  // R8: a parked frame stays put while its mailbox is locked
  assert_park_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && blocked) |=> (held_q && $stable(park_q)));
endmodule

// File: rtl/can_mb_lock.sv
module can_mb_lock #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_rd,
  input  logic [IDX_W-1:0] cs_idx,
  input  logic             tmr_rd,
  output logic             lock_vld,
  output logic [IDX_W-1:0] lock_idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_vld <= 1'b0;
      lock_idx <= '0;
    end else if (cs_rd) begin
      lock_vld <= 1'b1;
      lock_idx <= cs_idx;
    end else if (tmr_rd) begin
      lock_vld <= 1'b0;
    end
  end

  assert_lock_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rd |=> (lock_vld && lock_idx == $past(cs_idx)));
  assert_lock_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_rd && !cs_rd) |=> !lock_vld);
endmodule

// File: rtl/can_mb_bank.sv
module can_mb_bank
  import can_mb_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 11,
  parameter int TS_W   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [ID_W-1:0]             in_id,
  input  logic [3:0]                  in_len,
  input  logic [63:0]                 in_data,
  input  logic                        cpu_rd,
  input  logic                        cpu_wr,
  input  logic [$clog2(NUM_MB)+2:0]   cpu_addr,
  input  logic [31:0]                 cpu_wdata,
  output logic [31:0]                 cpu_rdata,
  output logic                        irq
);
  localparam int IDX_W = $clog2(NUM_MB);
  localparam int AW    = IDX_W + 3;
  localparam int FW    = ID_W + LEN_W + DATA_W;

  logic [3:0]        code_q  [NUM_MB];
  logic [LEN_W-1:0]  len_q   [NUM_MB];
  logic [TS_W-1:0]   stamp_q [NUM_MB];
  logic [ID_W-1:0]   id_q    [NUM_MB];
  logic [DATA_W-1:0] data_q  [NUM_MB];
  logic [NUM_MB-1:0] iflag_q, imask_q;
  logic [ID_W-1:0]   mask_q;
  logic [TS_W-1:0]   timer_q;

  // CPU decode
  logic             mb_space, reg_space, wr_cs, wr_id, cs_rd, tmr_rd;
  logic [IDX_W-1:0] sel;
  assign mb_space  = !cpu_addr[AW-1];
  assign reg_space = cpu_addr[AW-1] && (cpu_addr[AW-2:2] == '0);
  assign sel       = cpu_addr[AW-2:2];
  assign wr_cs     = cpu_wr && mb_space && cpu_addr[1:0] == 2'd0;
  assign wr_id     = cpu_wr && mb_space && cpu_addr[1:0] == 2'd1;
  assign cs_rd     = cpu_rd && mb_space && cpu_addr[1:0] == 2'd0;
  assign tmr_rd    = cpu_rd && reg_space && cpu_addr[1:0] == 2'd0;

  // Candidate frame and matching
  logic               cand_valid, hit, blocked, store_en, lock_vld;
  logic [FW-1:0]      cand_frame;
  logic [ID_W-1:0]    cand_id;
  logic [LEN_W-1:0]   cand_len;
  logic [DATA_W-1:0]  cand_data;
  logic [IDX_W-1:0]   tgt, lock_idx;
  logic [NUM_MB-1:0]  active;
  logic [NUM_MB*ID_W-1:0] ids_flat;

  assign {cand_id, cand_len, cand_data} = cand_frame;

  for (genvar k = 0; k < NUM_MB; k++) begin : g_act
    assign active[k] = (code_q[k] != CODE_INACTIVE) && !(wr_cs && sel == IDX_W'(k));
    assign ids_flat[k*ID_W +: ID_W] = id_q[k];
  end

  assign blocked  = cand_valid && hit && lock_vld && lock_idx == tgt;
  assign store_en = cand_valid && hit && !blocked;

  can_mb_hold #(.FW(FW)) u_hold (
    .clk, .rst_n, .in_valid, .in_frame({in_id, in_len, in_data}), .in_ready,
    .blocked, .cand_valid, .cand_frame
  );

  can_mb_match #(.NUM(NUM_MB), .ID_W(ID_W), .IDX_W(IDX_W)) u_match (
    .clk, .rst_n, .cand_id, .mask(mask_q), .active, .ids(ids_flat), .hit, .idx(tgt)
  );

  can_mb_lock #(.IDX_W(IDX_W)) u_lock (
    .clk, .rst_n, .cs_rd, .cs_idx(sel), .tmr_rd, .lock_vld, .lock_idx
  );

  // Mailbox storage: CPU writes first, frame store last so it wins on ID
  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_MB; k++) begin
      if (!rst_n) begin
        code_q[k]  <= CODE_INACTIVE;
        len_q[k]   <= '0;
        stamp_q[k] <= '0;
        id_q[k]    <= '0;
        data_q[k]  <= '0;
      end else begin
        if (wr_cs && sel == IDX_W'(k)) begin
          code_q[k]  <= cpu_wdata[27:24];
          len_q[k]   <= cpu_wdata[19:16];
          stamp_q[k] <= cpu_wdata[TS_W-1:0];
        end
        if (wr_id && sel == IDX_W'(k)) id_q[k] <= cpu_wdata[ID_W-1:0];
        if (store_en && tgt == IDX_W'(k)) begin
          code_q[k]  <= code_after_store(code_q[k]);
          len_q[k]   <= cand_len;
          stamp_q[k] <= timer_q;
          id_q[k]    <= cand_id;
          data_q[k]  <= cand_data;
        end
      end
    end
  end

  // Control registers
  logic [NUM_MB-1:0] clr_mask, set_mask;
  assign clr_mask = (cpu_wr && reg_space && cpu_addr[1:0] == 2'd1) ? cpu_wdata[NUM_MB-1:0] : '0;
  assign set_mask = store_en ? (NUM_MB'(1) << tgt) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iflag_q <= '0;
      imask_q <= '0;
      mask_q  <= '1;
      timer_q <= '0;
    end else begin
      iflag_q <= (iflag_q & ~clr_mask) | set_mask;
      timer_q <= timer_q + 1'b1;
      if (cpu_wr && reg_space && cpu_addr[1:0] == 2'd2) imask_q <= cpu_wdata[NUM_MB-1:0];
      if (cpu_wr && reg_space && cpu_addr[1:0] == 2'd3) mask_q  <= cpu_wdata[ID_W-1:0];
    end
  end

  assign irq = |(iflag_q & imask_q);

  // Read path
  logic        busy;
  logic [31:0] rd_word;
  assign busy = store_en && tgt == sel;

  always_comb begin
    rd_word = '0;
    if (mb_space) begin
      case (cpu_addr[1:0])
        2'd0:    rd_word = {4'b0, code_q[sel] | {3'b0, busy}, 4'b0, len_q[sel], 16'(stamp_q[sel])};
        2'd1:    rd_word = 32'(id_q[sel]);
        2'd2:    rd_word = data_q[sel][31:0];
        default: rd_word = data_q[sel][63:32];
      endcase
    end else if (reg_space) begin
      case (cpu_addr[1:0])
        2'd0:    rd_word = 32'(timer_q);
        2'd1:    rd_word = 32'(iflag_q);
        2'd2:    rd_word = 32'(imask_q);
        default: rd_word = 32'(mask_q);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cpu_rdata <= '0;
    else if (cpu_rd) cpu_rdata <= rd_word;
  end

  assert_store_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |=> iflag_q[$past(tgt)]);
  assert_store_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |=> (code_q[$past(tgt)] == CODE_FULL || code_q[$past(tgt)] == CODE_OVERRUN));
  assert_no_locked_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && lock_vld) |-> (tgt != lock_idx));
endmodule

// File: tb/can_mb_bank_tb.sv
module can_mb_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [10:0] in_id = '0;
  logic [3:0]  in_len = '0;
  logic [63:0] in_data = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [6:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  can_mb_bank u_dut (.*);

  // ---------------- behavioural reference ----------------
  logic [3:0]  m_code  [16];
  logic [3:0]  m_len   [16];
  logic [15:0] m_stamp [16];
  logic [10:0] m_id    [16];
  logic [63:0] m_data  [16];
  logic [15:0] m_iflag, m_imask, m_timer;
  logic [10:0] m_mask;
  logic [31:0] m_rdata;
  bit          m_lockv, m_held;
  int          m_locki;
  logic [10:0] h_id;
  logic [3:0]  h_len;
  logic [63:0] h_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) begin
        m_code[k] = 0; m_len[k] = 0; m_stamp[k] = 0; m_id[k] = 0; m_data[k] = 0;
      end
      m_iflag = 0; m_imask = 0; m_timer = 0; m_mask = 11'h7FF; m_rdata = 0;
      m_lockv = 0; m_locki = 0; m_held = 0; h_id = 0; h_len = 0; h_data = 0;
    end else begin
      bit cv, hit, st;
      int tg, bx;
      logic [10:0] cid; logic [3:0] cln; logic [63:0] cdt;
      bx = cpu_addr[5:2];
      cv = m_held || in_valid;
      cid = m_held ? h_id : in_id; cln = m_held ? h_len : in_len; cdt = m_held ? h_data : in_data;
      hit = 0; tg = 0;
      for (int k = 0; k < 16; k++)
        if (!hit && m_code[k] != 0 && !(cpu_wr && !cpu_addr[6] && cpu_addr[1:0] == 0 && bx == k)
            && ((m_id[k] ^ cid) & m_mask) == 0) begin hit = 1; tg = k; end
      st = cv && hit && !(m_lockv && m_locki == tg);
      if (cv && hit && !st) begin
        if (!m_held) begin m_held = 1; h_id = in_id; h_len = in_len; h_data = in_data; end
      end else m_held = 0;
      if (cpu_rd) begin
        if (!cpu_addr[6]) begin
          case (cpu_addr[1:0])
            0: m_rdata = {4'b0, m_code[bx] | ((st && tg == bx) ? 4'b1 : 4'b0), 4'b0, m_len[bx], m_stamp[bx]};
            1: m_rdata = {21'b0, m_id[bx]};
            2: m_rdata = m_data[bx][31:0];
            default: m_rdata = m_data[bx][63:32];
          endcase
        end else if (cpu_addr[5:2] == 0) begin
          case (cpu_addr[1:0])
            0: m_rdata = {16'b0, m_timer};
            1: m_rdata = {16'b0, m_iflag};
            2: m_rdata = {16'b0, m_imask};
            default: m_rdata = {21'b0, m_mask};
          endcase
        end else m_rdata = 0;
        if (!cpu_addr[6] && cpu_addr[1:0] == 0) begin m_lockv = 1; m_locki = bx; end
        else if (cpu_addr == 7'h40) m_lockv = 0;
      end
      if (cpu_wr) begin
        if (!cpu_addr[6] && cpu_addr[1:0] == 0) begin
          m_code[bx] = cpu_wdata[27:24]; m_len[bx] = cpu_wdata[19:16]; m_stamp[bx] = cpu_wdata[15:0];
        end
        if (!cpu_addr[6] && cpu_addr[1:0] == 1) m_id[bx] = cpu_wdata[10:0];
        if (cpu_addr == 7'h41) m_iflag = m_iflag & ~cpu_wdata[15:0];
        if (cpu_addr == 7'h42) m_imask = cpu_wdata[15:0];
        if (cpu_addr == 7'h43) m_mask = cpu_wdata[10:0];
      end
      if (st) begin
        m_code[tg] = (m_code[tg] == 4'b0010 || m_code[tg] == 4'b0110) ? 4'b0110 : 4'b0010;
        m_len[tg] = cln; m_stamp[tg] = m_timer; m_id[tg] = cid; m_data[tg] = cdt;
        m_iflag[tg] = 1'b1;
      end
      m_timer = m_timer + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Every-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_req, " in_ready"}, {31'b0, in_ready}, {31'b0, !m_held});
      chk({cur_req, " irq"}, {31'b0, irq}, {31'b0, |(m_iflag & m_imask)});
      chk({cur_req, " rdata"}, cpu_rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); cpu_rd = 1; cpu_addr = a;
    @(negedge clk); cpu_rd = 0; d = cpu_rdata;
  endtask

  task automatic send(input logic [10:0] id, input logic [3:0] ln, input logic [63:0] dt);
    @(negedge clk); in_valid = 1; in_id = id; in_len = ln; in_data = dt;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 0;
  endtask

  task automatic arm(input int mb, input logic [10:0] id);
    wr(7'(mb * 4 + 1), {21'b0, id});
    wr(7'(mb * 4), 32'h0400_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, t0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    chk("R1 in_ready", {31'b0, in_ready}, 32'd1);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 rdata", cpu_rdata, 32'd0);
    rd(7'h0C, d); chk("R1 code inactive", d, 32'd0);
    rd(7'h43, d); chk("R1 mask ones", d, 32'h7FF);
    rd(7'h41, d); chk("R1 flags", d, 32'd0);
    rd(7'h40, d);

    // R2 arming a mailbox
    cur_req = "R2";
    arm(2, 11'h123);
    rd(7'h08, d); chk("R2 empty code", d & 32'h0F00_0000, 32'h0400_0000);
    rd(7'h40, d);

    // R3/R4/R5 store
    cur_req = "R4";
    send(11'h123, 4'd8, 64'h8877_6655_4433_2211);
    rd(7'h08, d); chk("R4 full code and len", d & 32'h0F0F_0000, 32'h0208_0000);
    rd(7'h09, d); chk("R3 stored id", d, 32'h123);
    rd(7'h0A, d); chk("R4 data low", d, 32'h4433_2211);
    rd(7'h0B, d); chk("R4 data high", d, 32'h8877_6655);
    rd(7'h40, d);
    cur_req = "R5";
    rd(7'h41, d); chk("R5 flag set", d, 32'h0004);
    cur_req = "R6";
    @(negedge clk); chk("R6 irq masked", {31'b0, irq}, 32'd0);
    wr(7'h42, 32'h0004); chk("R6 irq enabled", {31'b0, irq}, 32'd1);
    cur_req = "R5";
    wr(7'h41, 32'h0004); chk("R5 w1c clears irq", {31'b0, irq}, 32'd0);

    // R10 code stays full after service
    cur_req = "R10";
    rd(7'h08, d); rd(7'h40, d);
    rd(7'h08, d); chk("R10 still full", d & 32'h0F00_0000, 32'h0200_0000);
    rd(7'h40, d);

    // R4 overrun
    cur_req = "R4";
    send(11'h123, 4'd2, 64'h55);
    rd(7'h08, d); chk("R4 overrun code", d & 32'h0F0F_0000, 32'h0602_0000);
    rd(7'h40, d);

    // R3 masking, priority, drop
    cur_req = "R3";
    wr(7'h43, 32'h7F0);
    arm(5, 11'h200); arm(6, 11'h200);
    send(11'h20A, 4'd1, 64'hAA);
    rd(7'h41, d); chk("R3 lowest wins", d, 32'h0024);
    rd(7'h15, d); chk("R3 id replaced", d, 32'h20A);
    send(11'h300, 4'd1, 64'hBB);
    rd(7'h41, d); chk("R3 unmatched dropped", d, 32'h0024);
    wr(7'h41, 32'hFFFF);

    // R7/R8 lock and parking
    cur_req = "R8";
    wr(7'h14, 32'h0);
    rd(7'h18, d);
    send(11'h201, 4'd3, 64'hC0FFEE);
    chk("R8 ready low while parked", {31'b0, in_ready}, 32'd0);
    rd(7'h41, d); chk("R8 no store while locked", d, 32'h0000);
    cur_req = "R7";
    rd(7'h04, d);
    @(negedge clk);
    chk("R7 lock moved frees input", {31'b0, in_ready}, 32'd1);
    rd(7'h41, d); chk("R7 parked frame landed", d, 32'h0040);
    rd(7'h1A, d); chk("R8 parked data", d, 32'h00C0_FFEE);
    rd(7'h40, d);
    wr(7'h41, 32'hFFFF);

    // R2 same-cycle write excludes the mailbox
    cur_req = "R2";
    wr(7'h43, 32'h7FF);
    arm(7, 11'h055);
    @(negedge clk);
    cpu_wr = 1; cpu_addr = 7'h1C; cpu_wdata = 32'h0400_0000;
    in_valid = 1; in_id = 11'h055; in_len = 4'd1; in_data = 64'h1;
    @(negedge clk); cpu_wr = 0; in_valid = 0;
    rd(7'h41, d); chk("R2 write wins over frame", d, 32'h0000);

    // R9 busy on collision with a store
    cur_req = "R9";
    arm(8, 11'h077);
    @(negedge clk);
    cpu_rd = 1; cpu_addr = 7'h20;
    in_valid = 1; in_id = 11'h077; in_len = 4'd4; in_data = 64'h9;
    @(negedge clk); cpu_rd = 0; in_valid = 0;
    chk("R9 busy code", cpu_rdata & 32'h0F00_0000, 32'h0500_0000);
    rd(7'h40, d);
    rd(7'h20, d); chk("R9 full after busy", d & 32'h0F00_0000, 32'h0200_0000);

    // R11 timer and read latency
    cur_req = "R11";
    rd(7'h40, t0); rd(7'h40, d);
    chk("R11 timer step", d - t0, 32'd2);
    repeat (3) @(negedge clk);
    chk("R11 rdata holds", cpu_rdata, d);

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule